// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

A small register of parameterised width (four bits by default) whose next value on each rising clock edge comes from one of four sources picked by a 2-bit mode input. It can keep its value, move every bit one place toward the low end, move every bit one place toward the high end, or take a whole word from its parallel input. Each shift direction has its own serial input, which fills the vacated end of the word. A synchronous clear wins over every mode.

Bit 0 of the word is position A and the top bit is position D. A right shift moves data from A toward D, and a left shift moves data from D toward A. The bit that a shift is about to push out is always visible on the parallel output before the edge. So one instance loaded in parallel and shifted right can feed its position D into the right serial input of a second instance. That pair forms a parallel-to-serial transmitter and a serial-to-parallel receiver.

Top module: `ushift_reg`

## Requirements
- R1: When `clr` is 1 at a rising edge, `q` is all zeros after that edge, whatever `mode` is.
- R2: With `clr` 0 and `mode` = 2'b11, `q` takes the value of `par_in` at the edge.
- R3: With `clr` 0 and `mode` = 2'b10 (left), each `q[i]` takes the old `q[i+1]`, and `q[WIDTH-1]` (position D) takes `sin_left`.
- R4: With `clr` 0 and `mode` = 2'b01 (right), each `q[i]` takes the old `q[i-1]`, and `q[0]` (position A) takes `sin_right`.
- R5: With `clr` 0 and `mode` = 2'b00, `q` keeps its value, and `par_in`, `sin_left` and `sin_right` have no effect.
- R6: Before a right-shift edge, the bit leaving the word is on `q[WIDTH-1]`. Before a left-shift edge, the bit leaving the word is on `q[0]`.
- R7: An instance whose `q[WIDTH-1]` drives the `sin_right` input of a second instance, with both shifting right for WIDTH edges, leaves the first instance's loaded word in the second instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, overrides the mode |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| par_in | input | WIDTH | Parallel word; bit 0 is position A |
| sin_left | input | 1 | Serial input that enters position D on a left shift |
| sin_right | input | 1 | Serial input that enters position A on a right shift |
| q | output | WIDTH | Registered stored word |

## Verification
Every operation changes `q` exactly one edge after its inputs are applied. The bench sets inputs just after a falling edge and reads `q` at the next falling edge, so each result is checked half a period after the edge that made it. The far-end bit of R6 is read before the shifting edge, and the serial link of R7 is read after WIDTH consecutive edges. The assertions compare `q` with the values that `par_in`, the serial inputs and `q` had one edge earlier.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  typedef struct packed {
    logic hold;
    logic shr;
    logic shl;
    logic load;
  } sel_t;
endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
  import ushift_pkg::*;
(
  input  logic [1:0] mode,
  output sel_t       sel
);
  always_comb begin
    sel = '0;
    case (mode_e'(mode))
      MODE_SHR:  sel.shr  = 1'b1;
      MODE_SHL:  sel.shl  = 1'b1;
      MODE_LOAD: sel.load = 1'b1;
      default:   sel.hold = 1'b1;
    endcase
  end
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
  import ushift_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  sel_t sel,
  input  logic par_bit,
  input  logic from_lower,
  input  logic from_upper,
  output logic q_bit
);
  logic nxt;

  // one-hot AND-OR selector in front of the flip-flop
  always_comb begin
    nxt = (sel.hold & q_bit)
        | (sel.shr  & from_lower)
        | (sel.shl  & from_upper)
        | (sel.load & par_bit);
  end

  always_ff @(posedge clk) begin
    if (clr) q_bit <= 1'b0;
    else     q_bit <= nxt;
  end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             sin_left,
  input  logic             sin_right,
  output logic [WIDTH-1:0] q
);
  import ushift_pkg::*;

  localparam int TOP = WIDTH - 1;

  sel_t sel;

  ushift_mode_dec dec_i (
    .mode (mode),
    .sel  (sel)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic lower_src;
    logic upper_src;
    if (i == 0) begin : g_first
      assign lower_src = sin_right;
    end else begin : g_mid_lo
      assign lower_src = q[i-1];
    end
    if (i == TOP) begin : g_last
      assign upper_src = sin_left;
    end else begin : g_mid_hi
      assign upper_src = q[i+1];
    end

    ushift_cell cell_i (
      .clk        (clk),
      .clr        (clr),
      .sel        (sel),
      .par_bit    (par_in[i]),
      .from_lower (lower_src),
      .from_upper (upper_src),
      .q_bit      (q[i])
    );
  end
endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             sin_left,
  input logic             sin_right,
  input logic [WIDTH-1:0] q
);
  a_r1_clear: assert property (@(posedge clk) clr |=> (q == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b11) |=> (q == $past(par_in)));

  a_r3_shift_left: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b10) |=> (q == {$past(sin_left), $past(q[WIDTH-1:1])}));

  a_r4_shift_right: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b01) |=> (q == {$past(q[WIDTH-2:0]), $past(sin_right)}));

  a_r5_hold: assert property (@(posedge clk) disable iff (clr)
    (mode == 2'b00) |=> $stable(q));
endmodule

bind ushift_reg ushift_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/ushift_reg_tb_top.sv
module ushift_reg_tb_top;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         clr;
  logic [1:0]   mode, rx_mode;
  logic [W-1:0] par_in;
  logic         sin_left, sin_right;
  logic [W-1:0] q, rx_q;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ushift_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .clr(clr), .mode(mode), .par_in(par_in),
    .sin_left(sin_left), .sin_right(sin_right), .q(q)
  );

  ushift_reg #(.WIDTH(W)) rx_i (
    .clk(clk), .clr(clr), .mode(rx_mode), .par_in('0),
    .sin_left(1'b0), .sin_right(q[W-1]), .q(rx_q)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m);
    mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    clr = 1'b1; mode = 2'b11; par_in = 4'hF;
    @(negedge clk);
    chk("R1 reset", q, '0);
    chk("R1 reset rx", rx_q, '0);
    clr = 1'b0;
  endtask

  task automatic t_load();
    par_in = 4'b1010; step(2'b11);
    chk("R2 load 1010", q, 4'b1010);
    par_in = 4'b0111; step(2'b11);
    chk("R2 load 0111", q, 4'b0111);
  endtask

  task automatic t_shl();
    par_in = 4'b1001; step(2'b11);
    sin_left = 1'b0; step(2'b10);
    chk("R3 left in 0", q, 4'b0100);
    sin_left = 1'b1; step(2'b10);
    chk("R3 left in 1", q, 4'b1010);
    step(2'b10);
    chk("R3 left again", q, 4'b1101);
  endtask

  task automatic t_shr();
    par_in = 4'b1001; step(2'b11);
    sin_right = 1'b1; step(2'b01);
    chk("R4 right in 1", q, 4'b0011);
    sin_right = 1'b0; step(2'b01);
    chk("R4 right in 0", q, 4'b0110);
    step(2'b01);
    chk("R4 right again", q, 4'b1100);
  endtask

  task automatic t_hold();
    par_in = 4'b0110; step(2'b11);
    par_in = 4'b1001; sin_left = 1'b1; sin_right = 1'b1;
    step(2'b00);
    chk("R5 hold", q, 4'b0110);
    par_in = 4'b1111; sin_left = 1'b0; sin_right = 1'b0;
    step(2'b00);
    chk("R5 hold again", q, 4'b0110);
  endtask

  task automatic t_clear_override();
    par_in = 4'b1111; step(2'b11);
    clr = 1'b1; step(2'b11);
    chk("R1 clear over load", q, '0);
    clr = 1'b0; par_in = 4'b1011; step(2'b11);
    clr = 1'b1; sin_left = 1'b1; step(2'b10);
    chk("R1 clear over shift", q, '0);
    clr = 1'b0;
  endtask

  task automatic t_far_end();
    par_in = 4'b1000; step(2'b11);
    chk("R6 right out bit before edge", {3'b0, q[W-1]}, 4'b0001);
    sin_right = 1'b0; step(2'b01);
    chk("R6 right out bit gone", {3'b0, q[W-1]}, 4'b0000);
    par_in = 4'b0001; step(2'b11);
    chk("R6 left out bit before edge", {3'b0, q[0]}, 4'b0001);
    sin_left = 1'b0; step(2'b10);
    chk("R6 left out bit gone", {3'b0, q[0]}, 4'b0000);
  endtask

  task automatic t_link(input logic [W-1:0] word);
    par_in = word; rx_mode = 2'b00; step(2'b11);
    for (int k = 0; k < W; k++) begin
      rx_mode = 2'b01; sin_right = 1'b0;
      step(2'b01);
    end
    rx_mode = 2'b00;
    chk("R7 serial link", rx_q, word);
  endtask

  initial begin
    clr = 1'b1; mode = 2'b00; rx_mode = 2'b00;
    par_in = '0; sin_left = 1'b0; sin_right = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_shl();
    t_shr();
    t_hold();
    t_clear_override();
    t_far_end();
    t_link(4'b1101);
    t_link(4'b0110);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule